// File: doc/BRIEF.md
# Jitter-Attenuating Elastic Bit Store

This block is a single-channel elastic store for the bit stream of a T1 or E1 line. Incoming bits arrive on a write strobe that may be jittery or have gaps. The block sends them out on evenly spaced read strobes. A numerically controlled oscillator runs on the fast master clock and produces the read strobes. Its increment is the nominal line rate plus a term scaled from the fill error. As a result, the read rate follows the long-term average write rate and the fill level settles around half of the store.

The store holds either 32 or 64 bits. The E1 reduced-bandwidth selection forces the store to 64 bits. When the fill level comes within two bits of empty or full, the loop switches to a wide tracking gain, and it returns to the narrow gain once the level is back outside that window. Any change of the effective depth, and the first cycle after reset, reloads the store at half-full with zero bits. A bypass input sends the input straight to the output.

Top module: `jitter_elastic_store`

## Requirements
- R1: In the first clock after reset is released, the store reinitialises. `resync` is high for the one cycle that follows. At that point `fill_level` equals half the effective depth, both sticky flags are 0 and `out_strobe` is 0.
- R2: The effective depth is 64 when `deep_sel`=1, or when `line_e1`=1 and `bw_low`=1; otherwise it is 32. A change of effective depth reloads the store at half the new depth, clears both sticky flags and pulses `resync`.
- R3: With no overflow and no underflow, the output bits are the preload of depth/2 zero bits followed by every written bit, in write order.
- R4: When writes arrive steadily at the nominal rate (one per 8 clocks at the default increment), `fill_level` stays within half-depth ±4.
- R5: `wide_track` is 1 exactly when `fill_level` ≤ 2 or `fill_level` ≥ depth−2.
- R6: A write gap of 20 bit periods at depth 32, or of 50 bit periods at depth 64, followed by a catch-up burst, raises neither sticky flag and keeps R3 intact.
- R7: A write while `fill_level` equals the depth is dropped. `fill_level` never exceeds the depth, and `ovf_flag` is set and stays set until the next reinitialisation.
- R8: A read strobe while the store is empty outputs a 0 bit with `out_strobe`=1 and sets `unf_flag`, which stays set until the next reinitialisation.
- R9: While `bypass`=1, `out_bit` equals `wr_bit` and `out_strobe` equals `wr_en` in the same cycle, and `fill_level` does not change.
- R10: While `line_e1`=0, `bw_low` has no effect: no `resync` occurs and the depth stays as `deep_sel` selects.
- R11: Outside bypass, `out_strobe` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_e1 | input | 1 | 1 = E1 line, 0 = T1 line |
| bw_low | input | 1 | E1 reduced-bandwidth select (forces depth 64) |
| deep_sel | input | 1 | 1 = 64-bit store, 0 = 32-bit store |
| bypass | input | 1 | Pass input straight to output |
| wr_en | input | 1 | Input bit strobe |
| wr_bit | input | 1 | Input bit |
| out_bit | output | 1 | Output bit |
| out_strobe | output | 1 | Output bit strobe |
| resync | output | 1 | One-cycle pulse after a reinitialisation |
| wide_track | output | 1 | Loop is in wide tracking gain |
| fill_level | output | 7 | Bits currently held |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
Underflow is the hardest state to reach from the ports. Near empty, the loop slows the read oscillator to its minimum increment, so a short gap never drains the store. The stimulus first writes a run of ones, then holds the write strobe low for thousands of clocks. Once `fill_level` has been seen at zero, it waits for the next read strobe and checks that the strobe carries a 0 bit. A second hard case is a gap at the edge of the tolerance. The stimulus reaches it by withholding writes for exactly 20 or 50 bit periods and then bursting the missed bits at four times the line rate, while the scoreboard follows every bit.

// File: rtl/jes_pkg.sv
package jes_pkg;

  // next pointer value, wrapping at the active depth
  function automatic int wrap_inc(int p, int d);
    return (p + 1 >= d) ? 0 : p + 1;
  endfunction

  // loop gain shift: wide tracking wins, then T1, then E1 normal / reduced
  function automatic int loop_shift(logic e1, logic low, logic wide,
                                    int sh_t1, int sh_e1, int sh_low, int sh_wide);
    if (wide)       return sh_wide;
    else if (!e1)   return sh_t1;
    else if (low)   return sh_low;
    else            return sh_e1;
  endfunction

  // oscillator increment from fill error, clamped to [min_inc, max_inc]
  function automatic int rate_inc(int fill, int depth, int shift, int nom,
                                  int gain_log2, int min_inc, int max_inc);
    int err;
    int adj;
    int v;
    err = fill - depth / 2;
    adj = (err * (1 << gain_log2)) >>> shift;
    v = nom + adj;
    if (v < min_inc) v = min_inc;
    if (v > max_inc) v = max_inc;
    return v;
  endfunction

endpackage

// File: rtl/jes_mode_ctrl.sv
module jes_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_sel,
  input  logic line_e1,
  input  logic bw_low,
  output logic eff_deep,
  output logic init_evt,
  output logic resync
);
  logic cur_deep;
  logic pend;

  assign eff_deep = deep_sel | (line_e1 & bw_low);
  assign init_evt = pend | (eff_deep != cur_deep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_deep <= 1'b0;
      pend     <= 1'b1;
      resync   <= 1'b0;
    end else begin
      cur_deep <= eff_deep;
      pend     <= 1'b0;
      resync   <= init_evt;
    end
  end
endmodule

// File: rtl/jes_rate_nco.sv
module jes_rate_nco #(
  parameter int ACC_W     = 16,
  parameter int FILL_W    = 7,
  parameter int MAX_DEPTH = 64,
  parameter int NOM_INC   = 8192,
  parameter int GAIN_LOG2 = 9,
  parameter int MIN_INC   = 512,
  parameter int SH_T1     = 4,
  parameter int SH_E1     = 5,
  parameter int SH_LOW    = 7,
  parameter int SH_WIDE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              init_evt,
  input  logic              eff_deep,
  input  logic              line_e1,
  input  logic              bw_low,
  input  logic              wide,
  input  logic [FILL_W-1:0] fill,
  output logic              rd_tick
);
  localparam int MAX_INC = (1 << (ACC_W - 1)) - 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] inc;
  logic [ACC_W:0]   sum;
  int               depth;
  int               shift;

  always_comb begin
    depth = eff_deep ? MAX_DEPTH : MAX_DEPTH / 2;
    shift = jes_pkg::loop_shift(line_e1, bw_low, wide, SH_T1, SH_E1, SH_LOW, SH_WIDE);
    inc   = ACC_W'(jes_pkg::rate_inc(int'(fill), depth, shift, NOM_INC,
                                     GAIN_LOG2, MIN_INC, MAX_INC));
    sum   = {1'b0, acc} + {1'b0, inc};
  end

  assign rd_tick = run & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || init_evt) acc <= '0;
    else if (run)           acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/jes_bit_store.sv
module jes_bit_store #(
  parameter int MAX_DEPTH = 64,
  parameter int WIN       = 2,
  parameter int FILL_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_evt,
  input  logic              eff_deep,
  input  logic              run,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic              rd_tick,
  output logic [FILL_W-1:0] fill,
  output logic [FILL_W-1:0] depth,
  output logic              wide,
  output logic              rd_do,
  output logic              rd_empty,
  output logic              wr_drop,
  output logic              q_bit,
  output logic              q_strobe,
  output logic              ovf,
  output logic              unf
);
  localparam int PTR_W = $clog2(MAX_DEPTH);

  logic [MAX_DEPTH-1:0] mem;
  logic [PTR_W-1:0]     wr_ptr;
  logic [PTR_W-1:0]     rd_ptr;
  logic [FILL_W-1:0]    half;
  logic                 wr_try;
  logic                 wr_take;
  logic                 rd_take;

  assign depth    = eff_deep ? FILL_W'(MAX_DEPTH) : FILL_W'(MAX_DEPTH / 2);
  assign half     = depth >> 1;
  assign wide     = (fill <= FILL_W'(WIN)) || (fill >= depth - FILL_W'(WIN));
  assign rd_do    = run & rd_tick;
  assign rd_empty = rd_do & (fill == '0);
  assign rd_take  = rd_do & (fill != '0);
  assign wr_try   = run & wr_en;
  assign wr_drop  = wr_try & (fill == depth);
  assign wr_take  = wr_try & ~wr_drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem      <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      q_bit    <= 1'b0;
      q_strobe <= 1'b0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else if (init_evt) begin
      mem      <= '0;
      wr_ptr   <= PTR_W'(half);
      rd_ptr   <= '0;
      fill     <= half;
      q_bit    <= 1'b0;
      q_strobe <= 1'b0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      q_strobe <= rd_do;
      if (rd_take) begin
        q_bit  <= mem[rd_ptr];
        rd_ptr <= PTR_W'(jes_pkg::wrap_inc(int'(rd_ptr), int'(depth)));
      end else if (rd_empty) begin
        q_bit  <= 1'b0;
      end
      if (wr_take) begin
        mem[wr_ptr] <= wr_bit;
        wr_ptr      <= PTR_W'(jes_pkg::wrap_inc(int'(wr_ptr), int'(depth)));
      end
      fill <= fill + FILL_W'(wr_take) - FILL_W'(rd_take);
      if (wr_drop)  ovf <= 1'b1;
      if (rd_empty) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store #(
  parameter int MAX_DEPTH = 64,
  parameter int WIN       = 2,
  parameter int ACC_W     = 16,
  parameter int NOM_INC   = 8192,
  parameter int GAIN_LOG2 = 9,
  parameter int MIN_INC   = 512,
  parameter int SH_T1     = 4,
  parameter int SH_E1     = 5,
  parameter int SH_LOW    = 7,
  parameter int SH_WIDE   = 0,
  localparam int FILL_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_e1,
  input  logic              bw_low,
  input  logic              deep_sel,
  input  logic              bypass,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic              out_bit,
  output logic              out_strobe,
  output logic              resync,
  output logic              wide_track,
  output logic [FILL_W-1:0] fill_level,
  output logic              ovf_flag,
  output logic              unf_flag
);
  logic              eff_deep;
  logic              init_evt;
  logic              run;
  logic              rd_tick;
  logic              rd_do;
  logic              rd_empty;
  logic              wr_drop;
  logic              q_bit;
  logic              q_strobe;
  logic [FILL_W-1:0] depth;

  assign run = ~init_evt & ~bypass;

  jes_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .line_e1(line_e1),
    .bw_low(bw_low), .eff_deep(eff_deep), .init_evt(init_evt), .resync(resync)
  );

  jes_rate_nco #(
    .ACC_W(ACC_W), .FILL_W(FILL_W), .MAX_DEPTH(MAX_DEPTH), .NOM_INC(NOM_INC),
    .GAIN_LOG2(GAIN_LOG2), .MIN_INC(MIN_INC), .SH_T1(SH_T1), .SH_E1(SH_E1),
    .SH_LOW(SH_LOW), .SH_WIDE(SH_WIDE)
  ) u_nco (
    .clk(clk), .rst_n(rst_n), .run(run), .init_evt(init_evt), .eff_deep(eff_deep),
    .line_e1(line_e1), .bw_low(bw_low), .wide(wide_track), .fill(fill_level),
    .rd_tick(rd_tick)
  );

  jes_bit_store #(.MAX_DEPTH(MAX_DEPTH), .WIN(WIN), .FILL_W(FILL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .init_evt(init_evt), .eff_deep(eff_deep), .run(run),
    .wr_en(wr_en), .wr_bit(wr_bit), .rd_tick(rd_tick), .fill(fill_level),
    .depth(depth), .wide(wide_track), .rd_do(rd_do), .rd_empty(rd_empty),
    .wr_drop(wr_drop), .q_bit(q_bit), .q_strobe(q_strobe), .ovf(ovf_flag),
    .unf(unf_flag)
  );

  assign out_bit    = bypass ? wr_bit : q_bit;
  assign out_strobe = bypass ? wr_en  : q_strobe;
endmodule

// File: rtl/jes_checker.sv
module jes_checker #(parameter int FILL_W = 7) (
  input logic              clk,
  input logic              rst_n,
  input logic              bypass,
  input logic              init_evt,
  input logic              resync,
  input logic [FILL_W-1:0] fill_level,
  input logic [FILL_W-1:0] depth,
  input logic              ovf_flag,
  input logic              rd_empty,
  input logic              rd_do,
  input logic              wr_drop,
  input logic              out_strobe,
  input logic              out_bit
);
  assert_resync_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> resync);

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= depth);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !init_evt) |=> ovf_flag);

  assert_drop_keeps_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !rd_do) |=> $stable(fill_level));

  assert_empty_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |=> (bypass || (out_strobe && !out_bit)));

  assert_bypass_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !init_evt) |=> $stable(fill_level));

  assert_spaced_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && out_strobe) |=> (bypass || !out_strobe));
endmodule

bind jitter_elastic_store jes_checker #(.FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .init_evt(init_evt), .resync(resync),
  .fill_level(fill_level), .depth(depth), .ovf_flag(ovf_flag), .rd_empty(rd_empty),
  .rd_do(rd_do), .wr_drop(wr_drop), .out_strobe(out_strobe), .out_bit(out_bit)
);

// File: tb/jitter_elastic_store_test.sv
module jitter_elastic_store_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_e1 = 1'b0, bw_low = 1'b0, deep_sel = 1'b0, bypass = 1'b0;
  logic       wr_en = 1'b0, wr_bit = 1'b0;
  logic       out_bit, out_strobe, resync, wide_track, ovf_flag, unf_flag;
  logic [6:0] fill_level;

  int checks = 0, errors = 0, resync_cnt = 0, sb_err = 0, sb_cnt = 0;
  bit sb_on = 1'b0;
  bit finished = 1'b0;
  logic exp_q[$];
  int lfsr = 32'h1ace;

  always #5 clk = ~clk;

  jitter_elastic_store uut (
    .clk(clk), .rst_n(rst_n), .line_e1(line_e1), .bw_low(bw_low), .deep_sel(deep_sel),
    .bypass(bypass), .wr_en(wr_en), .wr_bit(wr_bit), .out_bit(out_bit),
    .out_strobe(out_strobe), .resync(resync), .wide_track(wide_track),
    .fill_level(fill_level), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  function automatic int exp_depth();
    return (deep_sel || (line_e1 && bw_low)) ? 64 : 32;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resync) begin
      resync_cnt++;
      exp_q.delete();
      for (int i = 0; i < exp_depth() / 2; i++) exp_q.push_back(1'b0);
    end else if (rst_n && sb_on && !bypass && out_strobe) begin
      sb_cnt++;
      if (exp_q.size() == 0) begin
        sb_err++;
        $display("FAIL R3: output bit with empty expectation queue, actual %0d expected none", out_bit);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (out_bit !== e) begin
          sb_err++;
          $display("FAIL R3: output bit actual %0d expected %0d", out_bit, e);
        end
      end
    end
  end

  function automatic logic next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
    return lfsr[0];
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // one bit written, followed by gap-1 idle cycles
  task automatic put(logic b, int gap);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_bit = b;
    if (sb_on) exp_q.push_back(b);
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (gap > 2) idle(gap - 2);
  endtask

  task automatic check_sb(string tag);
    chk(sb_err == 0, tag, sb_err, 0);
    sb_err = 0;
  endtask

  initial begin
    int mn, mx;
    bit seen_zero;
    int v;
    idle(3);
    @(negedge clk);
    chk(fill_level == 0 && out_strobe == 1'b0 && resync == 1'b0, "R1 in reset", fill_level, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(resync == 1'b1, "R1 resync pulse", resync, 1);
    chk(fill_level == 16, "R1 half fill", fill_level, 16);
    chk(!ovf_flag && !unf_flag, "R1 flags clear", ovf_flag + unf_flag, 0);
    @(negedge clk);
    chk(resync == 1'b0, "R1 pulse one cycle", resync, 0);
    chk(wide_track == 1'b0, "R5 not wide at half", wide_track, 0);

    // steady nominal writes (R3, R4)
    sb_on = 1'b1;
    for (int i = 0; i < 150; i++) put(next_rand(), 8);
    mn = 99; mx = 0;
    for (int i = 0; i < 150; i++) begin
      put(next_rand(), 8);
      if (fill_level < mn) mn = fill_level;
      if (fill_level > mx) mx = fill_level;
    end
    chk(mn >= 12 && mx <= 20, "R4 fill window steady", mx, 16);
    check_sb("R3 steady stream");

    // jittery writes, average nominal (R3, R4)
    for (int i = 0; i < 200; i++) put(next_rand(), (i % 2) ? 11 : 5);
    chk(fill_level >= 12 && fill_level <= 20, "R4 fill window jitter", fill_level, 16);
    check_sb("R3 jitter stream");

    // 20 UI gap at depth 32 (R6)
    idle(160);
    chk(wide_track == (fill_level <= 2), "R5 wide near empty", wide_track, fill_level <= 2);
    for (int i = 0; i < 20; i++) put(next_rand(), 2);
    for (int i = 0; i < 100; i++) put(next_rand(), 8);
    chk(!ovf_flag && !unf_flag, "R6 gap 20 at depth 32", ovf_flag + unf_flag, 0);
    check_sb("R6 gap 20 data");

    // T1: bw_low has no effect (R10)
    v = resync_cnt;
    bw_low = 1'b1;
    idle(20);
    chk(resync_cnt == v, "R10 no resync in T1", resync_cnt - v, 0);
    chk(fill_level <= 32 && !wide_track || fill_level <= 32, "R10 depth stays", fill_level, 16);
    for (int i = 0; i < 60; i++) put(next_rand(), 8);
    check_sb("R10 stream continues");

    // E1 reduced -> depth 64 (R2)
    line_e1 = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(resync_cnt == v + 1, "R2 resync on depth change", resync_cnt - v, 1);
    chk(fill_level == 32, "R2 half of 64", fill_level, 32);
    idle(4);
    for (int i = 0; i < 200; i++) put(next_rand(), 8);
    check_sb("R2 depth 64 stream");

    // 50 UI gap at depth 64 (R6)
    idle(400);
    for (int i = 0; i < 50; i++) put(next_rand(), 2);
    for (int i = 0; i < 150; i++) put(next_rand(), 8);
    chk(!ovf_flag && !unf_flag, "R6 gap 50 at depth 64", ovf_flag + unf_flag, 0);
    check_sb("R6 gap 50 data");

    // back to depth 32
    bw_low = 1'b0;
    idle(6);
    @(negedge clk);
    chk(fill_level <= 17 && fill_level >= 15, "R2 back to 32", fill_level, 16);

    // overflow (R7)
    sb_on = 1'b0;
    mx = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1 wr_en = 1'b1; wr_bit = 1'b1;
      @(negedge clk);
      if (fill_level > mx) mx = fill_level;
    end
    @(posedge clk); #1 wr_en = 1'b0;
    chk(mx == 32, "R7 fill capped at depth", mx, 32);
    chk(ovf_flag == 1'b1, "R7 overflow flag", ovf_flag, 1);
    chk(wide_track == (fill_level >= 30), "R5 wide near full", wide_track, fill_level >= 30);
    idle(40);
    chk(ovf_flag == 1'b1, "R7 overflow sticky", ovf_flag, 1);

    // underflow (R8): drain a store full of ones
    seen_zero = 1'b0;
    v = 0;
    for (int i = 0; i < 4000 && v == 0; i++) begin
      @(negedge clk);
      if (seen_zero && out_strobe) begin
        chk(out_bit == 1'b0, "R8 empty read gives 0", out_bit, 0);
        v = 1;
      end
      if (fill_level == 0) seen_zero = 1'b1;
    end
    chk(v == 1, "R8 empty read strobe seen", v, 1);
    @(negedge clk);
    chk(unf_flag == 1'b1, "R8 underflow flag", unf_flag, 1);

    // flags cleared by reinit (R2)
    deep_sel = 1'b1;
    idle(3);
    @(negedge clk);
    chk(!ovf_flag && !unf_flag, "R2 flags cleared", ovf_flag + unf_flag, 0);

    // bypass (R9)
    bypass = 1'b1;
    idle(2);
    @(negedge clk);
    mn = fill_level;
    for (int i = 0; i < 20; i++) begin
      logic b;
      b = next_rand();
      @(posedge clk); #1 wr_en = (i % 3 != 0); wr_bit = b;
      @(negedge clk);
      chk(out_bit == b && out_strobe == (i % 3 != 0), "R9 bypass pass-through",
          out_bit, b);
    end
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
    chk(fill_level == mn, "R9 fill frozen", fill_level, mn);
    bypass = 1'b0;

    // R11 spacing is also covered by the bound checker
    chk(sb_cnt > 500, "R3 scoreboard activity", sb_cnt, 500);
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        idle(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule